// File: doc/BRIEF.md
# Descriptor-Table Bus-Master DMA Engine

This block is the host-side sequencer for a disk channel's bus-master DMA. Software points it at a table of region descriptors in memory and sets a start bit. The engine reads one 8-byte descriptor at a time. It then hands fixed-size data beats for that region's address range to a drive-side protocol engine. Beats are only issued while the drive holds its DMA request high. When the drive lowers the request, movement stops, and it resumes when the request comes back.

The engine finishes when the last byte of a region flagged as end-of-table has been moved. At that point it drops its active status and masks the drive's request, so that later request pulses are ignored. If the drive is still requesting at that point, the engine flags an error. A drive interrupt is latched into status for software. Software ends the operation by clearing the start bit, and only after that reads the engine status and then the drive status.

Top module: `dma_bm_engine`

## Requirements
- R1: After reset, the status register (address 1) reads 0, the command register (address 0) reads 0, `dmarq_mask` is 1, and neither `desc_req` nor `mv_valid` is asserted, even with the drive request high.
- R2: Writing the command register with bit 0 (start) going from 0 to 1 sets status bit 0 (active), clears `dmarq_mask`, and requests the descriptor at the table base. The table base is written at address 2, and its low 3 bits are ignored.
- R3: A descriptor is 64 bits on `desc_rdata`. Bits 31:0 hold the region byte address. Bits 47:32 hold the byte count, a multiple of 4, where 0 means 65536. Bit 63 is the end-of-table flag. For a region, the engine issues count/4 beats on `mv_valid`/`mv_ready`, at addresses base, base+4, and onward.
- R4: No beat is issued in a cycle in which `drive_dmarq` is low.
- R5: After the last beat of a region without the end flag, the engine fetches the next descriptor at the previous descriptor address plus 8.
- R6: After the last beat of an end-flagged region, active clears and `dmarq_mask` sets. From then on, no beat or fetch occurs while the drive request is high.
- R7: `mv_dir` equals command bit 3 as written with the start edge. A later write to bit 3 that keeps start at 1 does not change it.
- R8: If the drive lowers its request before the table is exhausted, active stays 1, and beats resume once the request returns.
- R9: Status bit 1 (error) is set when the drive request is high after the table is exhausted. Writing 1 to status bit 1 clears it.
- R10: Status bit 2 (interrupt) is set by a `drive_irq` pulse. Writing 1 to bit 2 clears it, and writing 0 to it has no effect.
- R11: Writing the command register with start going from 1 to 0 halts the engine. No further beats or fetches occur, active clears, and `dmarq_mask` sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | 32 | Descriptor address |
| desc_ack | input | 1 | Descriptor data valid, accepts the request |
| desc_rdata | input | 64 | Descriptor contents |
| mv_valid | output | 1 | Data beat offered to the drive-side engine |
| mv_dir | output | 1 | 1: drive to memory, 0: memory to drive |
| mv_addr | output | 32 | Memory byte address of the beat |
| mv_ready | input | 1 | Drive-side engine accepts the beat |
| drive_dmarq | input | 1 | Drive DMA request |
| drive_irq | input | 1 | Drive interrupt pulse |
| dmarq_mask | output | 1 | Drive request is being ignored |

## Verification
A wrong sequencer state shows up at the ports within one cycle. It appears as a beat while masked, a stray or missing `desc_req`, or `dmarq_mask` out of step with active. A corrupted region counter or address register shows up as a wrong `mv_addr` on the very next beat, or as a wrong beat count per region. The bench sees a wrong count at the end of the region, when the next fetch or the end of the run comes early or late. Status faults show up on the next register read after the event that should have changed them.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W      = 32;
  localparam int REG_W       = 32;
  localparam int DESC_STRIDE = 8;

  localparam logic [1:0] REG_CMD = 2'd0;
  localparam logic [1:0] REG_STS = 2'd1;
  localparam logic [1:0] REG_TBL = 2'd2;

  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int STS_ACT   = 0;
  localparam int STS_ERR   = 1;
  localparam int STS_IRQ   = 2;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_MOVE  = 2'd2,
    S_DONE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs import dma_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              drive_irq,
  input  logic              seq_done,
  input  logic              seq_err,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              dir,
  output logic [ADDR_W-1:0] tbl_base
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(DESC_STRIDE - 1);

  logic              start_q, start_d;
  logic              dir_q, dir_d;
  logic [ADDR_W-1:0] tbl_q, tbl_d;
  logic              act_q, act_d;
  logic              err_q, err_d;
  logic              irq_q, irq_d;
  logic              wr_cmd, wr_sts, wr_tbl;

  assign wr_cmd = reg_wr && (reg_addr == REG_CMD);
  assign wr_sts = reg_wr && (reg_addr == REG_STS);
  assign wr_tbl = reg_wr && (reg_addr == REG_TBL);

  assign start_pulse = wr_cmd && reg_wdata[CMD_START] && !start_q;
  assign stop_pulse  = wr_cmd && !reg_wdata[CMD_START] && start_q;

  always_comb begin
    start_d = start_q;
    dir_d   = dir_q;
    tbl_d   = tbl_q;
    act_d   = act_q;
    err_d   = err_q;
    irq_d   = irq_q;
    if (wr_cmd)      start_d = reg_wdata[CMD_START];
    if (start_pulse) dir_d   = reg_wdata[CMD_DIR];
    if (wr_tbl)      tbl_d   = reg_wdata[ADDR_W-1:0] & ALIGN_MASK;
    if (start_pulse)                 act_d = 1'b1;
    else if (seq_done || stop_pulse) act_d = 1'b0;
    if (wr_sts && reg_wdata[STS_ERR]) err_d = 1'b0;
    if (seq_err)                      err_d = 1'b1;
    if (wr_sts && reg_wdata[STS_IRQ]) irq_d = 1'b0;
    if (drive_irq)                    irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      tbl_q   <= '0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      dir_q   <= dir_d;
      tbl_q   <= tbl_d;
      act_q   <= act_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CMD: begin
        reg_rdata[CMD_START] = start_q;
        reg_rdata[CMD_DIR]   = dir_q;
      end
      REG_STS: begin
        reg_rdata[STS_ACT] = act_q;
        reg_rdata[STS_ERR] = err_q;
        reg_rdata[STS_IRQ] = irq_q;
      end
      REG_TBL: reg_rdata[ADDR_W-1:0] = tbl_q;
      default: reg_rdata = '0;
    endcase
  end

  assign dir      = dir_q;
  assign tbl_base = tbl_q;

  assert_start_sets_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> act_q);
  assert_done_clears_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !act_q);
  assert_irq_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drive_irq |=> irq_q);
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq import dma_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_pulse,
  input  logic                stop_pulse,
  input  logic [ADDR_W-1:0]   tbl_base,
  output logic                desc_req,
  output logic [ADDR_W-1:0]   desc_addr,
  input  logic                desc_ack,
  input  logic [2*ADDR_W-1:0] desc_rdata,
  input  logic                drive_dmarq,
  input  logic                beat,
  input  logic                region_last,
  output logic                load,
  output logic [ADDR_W-1:0]   load_base,
  output logic [CNT_W-1:0]    load_cnt,
  output logic                moving,
  output logic                done_pulse,
  output logic                err_set,
  output logic                dmarq_mask
);
  localparam int EOT_BIT = 2*ADDR_W - 1;
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_STRIDE);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              eot_q, eot_d;
  logic              mask_q, mask_d;

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    eot_d      = eot_q;
    mask_d     = mask_q;
    load       = 1'b0;
    done_pulse = 1'b0;
    if (stop_pulse) begin
      state_d = S_IDLE;
      mask_d  = 1'b1;
    end else begin
      case (state_q)
        S_IDLE: if (start_pulse) begin
          state_d = S_FETCH;
          ptr_d   = tbl_base;
          mask_d  = 1'b0;
        end
        S_FETCH: if (desc_ack) begin
          load    = 1'b1;
          eot_d   = desc_rdata[EOT_BIT];
          ptr_d   = ptr_q + STRIDE;
          state_d = S_MOVE;
        end
        S_MOVE: if (beat && region_last) begin
          if (eot_q) begin
            state_d    = S_DONE;
            mask_d     = 1'b1;
            done_pulse = 1'b1;
          end else begin
            state_d = S_FETCH;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      eot_q   <= 1'b0;
      mask_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      eot_q   <= eot_d;
      mask_q  <= mask_d;
    end
  end

  assign desc_req   = (state_q == S_FETCH);
  assign desc_addr  = ptr_q;
  assign load_base  = desc_rdata[ADDR_W-1:0];
  assign load_cnt   = desc_rdata[ADDR_W +: CNT_W];
  assign moving     = (state_q == S_MOVE);
  assign err_set    = (state_q == S_DONE) && drive_dmarq;
  assign dmarq_mask = mask_q;

  assert_fetch_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && desc_ack) |=> !desc_req);
  assert_masked_outside_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE || state_q == S_DONE) |-> mask_q);
  assert_stop_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> (!desc_req && !moving));
endmodule

// File: rtl/dma_region_mover.sv
module dma_region_mover import dma_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_base,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              moving,
  input  logic              drive_dmarq,
  input  logic              mv_ready,
  output logic              mv_valid,
  output logic [ADDR_W-1:0] mv_addr,
  output logic              beat,
  output logic              region_last
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0]  BEAT_REM    = REM_W'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] BEAT_ADR    = ADDR_W'(BEAT_BYTES);
  localparam logic [REM_W-1:0]  FULL_REGION = {1'b1, {CNT_W{1'b0}}};

  logic [REM_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign mv_valid    = moving && drive_dmarq;
  assign beat        = mv_valid && mv_ready;
  assign region_last = (rem_q <= BEAT_REM);
  assign mv_addr     = addr_q;

  always_comb begin
    rem_d  = rem_q;
    addr_d = addr_q;
    if (load) begin
      rem_d  = (load_cnt == '0) ? FULL_REGION : {1'b0, load_cnt};
      addr_d = load_base;
    end else if (beat) begin
      rem_d  = rem_q - BEAT_REM;
      addr_d = addr_q + BEAT_ADR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else begin
      rem_q  <= rem_d;
      addr_q <= addr_d;
    end
  end

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !region_last) |=> (mv_addr == $past(mv_addr) + BEAT_ADR));
  assert_rem_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    moving |-> (rem_q != '0));
endmodule

// File: rtl/dma_bm_engine.sv
module dma_bm_engine import dma_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                desc_req,
  output logic [ADDR_W-1:0]   desc_addr,
  input  logic                desc_ack,
  input  logic [2*ADDR_W-1:0] desc_rdata,
  output logic                mv_valid,
  output logic                mv_dir,
  output logic [ADDR_W-1:0]   mv_addr,
  input  logic                mv_ready,
  input  logic                drive_dmarq,
  input  logic                drive_irq,
  output logic                dmarq_mask
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              start_pulse, stop_pulse, dir;
  logic [ADDR_W-1:0] tbl_base;
  logic              load, moving, done_pulse, err_set;
  logic [ADDR_W-1:0] load_base;
  logic [CNT_W-1:0]  load_cnt;
  logic              beat, region_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dma_regs u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .drive_irq(drive_irq), .seq_done(done_pulse), .seq_err(err_set),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .dir(dir), .tbl_base(tbl_base)
  );

  dma_desc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .tbl_base(tbl_base),
    .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack), .desc_rdata(desc_rdata),
    .drive_dmarq(drive_dmarq), .beat(beat), .region_last(region_last),
    .load(load), .load_base(load_base), .load_cnt(load_cnt), .moving(moving),
    .done_pulse(done_pulse), .err_set(err_set), .dmarq_mask(dmarq_mask)
  );

  dma_region_mover #(.CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_mover (
    .clk(clk), .rst_n(rst_int_n),
    .load(load), .load_base(load_base), .load_cnt(load_cnt),
    .moving(moving), .drive_dmarq(drive_dmarq), .mv_ready(mv_ready),
    .mv_valid(mv_valid), .mv_addr(mv_addr), .beat(beat), .region_last(region_last)
  );

  assign mv_dir = dir;

  assert_no_beat_masked_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    dmarq_mask |-> !mv_valid);
  assert_dir_held_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (moving && $past(moving)) |-> $stable(mv_dir));
endmodule

// File: tb/test_dma_bm_engine.sv
module test_dma_bm_engine;
  localparam logic [31:0] TBL = 32'h0000_1000;
  // {dir, pause, two regions, throttled ready, count0, count1}
  localparam logic [35:0] VEC [0:3] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 16'd32, 16'd0},
    {1'b0, 1'b1, 1'b1, 1'b1, 16'd64, 16'd16},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'd4,  16'd8},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'd0,  16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        desc_req, desc_ack;
  logic [31:0] desc_addr;
  logic [63:0] desc_rdata;
  logic        mv_valid, mv_dir, mv_ready;
  logic [31:0] mv_addr;
  logic        drive_dmarq, drive_irq, dmarq_mask;

  int checks = 0;
  int failures = 0;
  int scn_id = 0;
  logic [63:0] dtab [0:1];
  logic [31:0] base_a [0:1];
  int          len_a [0:1];
  logic        exp_dir;

  int beats, addr_bad, viol, dirbad, fetches, fetch_bad;

  always #5 clk = ~clk;

  dma_bm_engine i_dma_bm_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack),
    .desc_rdata(desc_rdata), .mv_valid(mv_valid), .mv_dir(mv_dir), .mv_addr(mv_addr),
    .mv_ready(mv_ready), .drive_dmarq(drive_dmarq), .drive_irq(drive_irq), .dmarq_mask(dmarq_mask)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  // beat monitor with its own address model
  initial begin
    int seen = -1;
    int ri = 0;
    int off = 0;
    forever begin
      @(negedge clk);
      if (seen != scn_id) begin
        seen = scn_id; beats = 0; ri = 0; off = 0;
        addr_bad = 0; viol = 0; dirbad = 0;
      end
      if (mv_valid && mv_ready) begin
        beats++;
        if (!drive_dmarq) viol++;
        if (mv_dir !== exp_dir) dirbad++;
        if (ri < 2) begin
          if (mv_addr !== base_a[ri] + 32'(off)) addr_bad++;
          off += 4;
          if (off >= len_a[ri]) begin ri++; off = 0; end
        end
      end
    end
  end

  // descriptor memory responder
  initial begin
    int seen = -1;
    desc_ack = 1'b0;
    desc_rdata = '0;
    forever begin
      @(negedge clk);
      if (seen != scn_id) begin seen = scn_id; fetches = 0; fetch_bad = 0; end
      desc_ack = desc_req;
      if (desc_req) begin
        if (desc_addr !== TBL + 32'(8 * fetches)) fetch_bad++;
        desc_rdata = (((desc_addr - TBL) >> 3) < 2) ? dtab[(desc_addr - TBL) >> 3] : 64'd0;
        fetches++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic prepare(input logic two, input logic [15:0] c0, input logic [15:0] c1,
                         input logic [31:0] b0, input logic [31:0] b1, input logic d);
    dtab[0] = {~two, 15'd0, c0, b0};
    dtab[1] = {1'b1, 15'd0, c1, b1};
    base_a[0] = b0; base_a[1] = b1;
    len_a[0] = (c0 == 0) ? 65536 : int'(c0);
    len_a[1] = two ? ((c1 == 0) ? 65536 : int'(c1)) : 0;
    exp_dir = d;
    scn_id++;
    reg_write(2'd2, TBL | 32'h5);
    reg_write(2'd0, 32'h0);
  endtask

  task automatic run_vec(input logic [35:0] v, input int vi);
    logic d, pause, two, rdy, paused;
    logic [31:0] st;
    int nbeats, snap, cyc;
    d = v[35]; pause = v[34]; two = v[33]; rdy = v[32];
    prepare(two, v[31:16], v[15:0], 32'h0002_0000 + 32'(vi * 256), 32'h0008_0000 + 32'(vi * 64), d);
    nbeats = (len_a[0] + len_a[1]) / 4;
    reg_write(2'd0, {28'd0, d, 3'b001});
    drive_dmarq = 1'b1;
    paused = 1'b0;
    cyc = 0;
    while (beats < nbeats && cyc < 100000) begin
      mv_ready = rdy ? ((cyc % 3) != 2) : 1'b1;
      if (pause && !paused && beats >= nbeats / 2) begin
        paused = 1'b1;
        drive_dmarq = 1'b0;
        snap = beats;
        repeat (4) @(posedge clk);
        reg_read(2'd1, st);
        chk($sformatf("R8 active held while request low v%0d", vi), st[0], 1'b1);
        chk($sformatf("R4 no beats while request low v%0d", vi), beats, snap);
        @(posedge clk); #1;
        drive_dmarq = 1'b1;
      end
      @(posedge clk); #1;
      cyc++;
    end
    drive_dmarq = 1'b0;
    mv_ready = 1'b1;
    repeat (3) @(posedge clk);
    reg_read(2'd1, st);
    chk($sformatf("R6 status after table end v%0d", vi), st[2:0], 3'b000);
    chk($sformatf("R6 mask after table end v%0d", vi), dmarq_mask, 1'b1);
    chk($sformatf("R3 beat count v%0d", vi), beats, nbeats);
    chk($sformatf("R3 beat addresses v%0d", vi), addr_bad, 0);
    chk($sformatf("R4 beats only with request v%0d", vi), viol, 0);
    chk($sformatf("R5 descriptor fetches v%0d", vi), fetches, two ? 2 : 1);
    chk($sformatf("R2 R5 fetch addresses v%0d", vi), fetch_bad, 0);
    chk($sformatf("R7 direction v%0d", vi), dirbad, 0);
    @(posedge clk); #1;
    drive_dmarq = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    drive_dmarq = 1'b0;
    chk($sformatf("R6 request ignored after end v%0d", vi), beats, nbeats);
    reg_write(2'd1, 32'h2);
  endtask

  initial begin
    logic [31:0] st;
    int snap, cyc;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    mv_ready = 1'b1; drive_dmarq = 1'b1; drive_irq = 1'b0;
    dtab[0] = '0; dtab[1] = '0; base_a[0] = '0; base_a[1] = '0;
    len_a[0] = 0; len_a[1] = 0; exp_dir = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state with the drive request high
    reg_read(2'd1, st);
    chk("R1 status after reset", st, 32'h0);
    reg_read(2'd0, st);
    chk("R1 command after reset", st, 32'h0);
    chk("R1 mask after reset", dmarq_mask, 1'b1);
    chk("R1 no fetch after reset", desc_req, 1'b0);
    chk("R1 no beat after reset", mv_valid, 1'b0);
    drive_dmarq = 1'b0;

    for (int vi = 0; vi < 4; vi++) run_vec(VEC[vi], vi);

    // R7 and R11: direction held through a mid-run write, then stop
    prepare(1'b0, 16'h0400, 16'h0, 32'h0003_0000, 32'h0, 1'b0);
    reg_write(2'd0, 32'h1);
    reg_read(2'd1, st);
    chk("R2 active after start", st[0], 1'b1);
    chk("R2 mask cleared after start", dmarq_mask, 1'b0);
    drive_dmarq = 1'b1;
    repeat (10) @(posedge clk);
    reg_write(2'd0, 32'h9);
    repeat (5) @(posedge clk);
    chk("R7 direction unchanged by mid-run write", dirbad, 0);
    chk("R7 mv_dir level", mv_dir, 1'b0);
    reg_write(2'd0, 32'h0);
    @(negedge clk);
    snap = beats;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R11 beats frozen after stop", beats, snap);
    chk("R11 stopped before region end", beats < 256, 1'b1);
    reg_read(2'd1, st);
    chk("R11 active cleared by stop", st[0], 1'b0);
    chk("R11 mask set by stop", dmarq_mask, 1'b1);
    chk("R11 no further fetch", fetches, 1);
    drive_dmarq = 1'b0;

    // R9 request still high after the table is exhausted
    prepare(1'b0, 16'd8, 16'd0, 32'h0004_0000, 32'h0, 1'b1);
    reg_write(2'd0, 32'h9);
    drive_dmarq = 1'b1;
    cyc = 0;
    while (beats < 2 && cyc < 100) begin @(posedge clk); #1; cyc++; end
    repeat (3) @(posedge clk);
    reg_read(2'd1, st);
    chk("R9 error set by request after end", st[1], 1'b1);
    chk("R6 active cleared with request high", st[0], 1'b0);
    chk("R6 no extra beats", beats, 2);
    drive_dmarq = 1'b0;
    reg_write(2'd1, 32'h2);
    reg_read(2'd1, st);
    chk("R9 error cleared by write one", st[1], 1'b0);

    // R10 interrupt latch
    @(posedge clk); #1 drive_irq = 1'b1;
    @(posedge clk); #1 drive_irq = 1'b0;
    reg_read(2'd1, st);
    chk("R10 interrupt latched", st[2], 1'b1);
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, st);
    chk("R10 write zero keeps interrupt", st[2], 1'b1);
    reg_write(2'd1, 32'h4);
    reg_read(2'd1, st);
    chk("R10 write one clears interrupt", st[2], 1'b0);

    summary();
    $finish;
  end
endmodule